// File: doc/BRIEF.md
# Two-Wire Slave for a 16-Bit Register Bank

This block lets an external master read and write a bank of 16-bit registers over a two-wire serial bus. The bus has a clock line driven by the master and a shared data line. The data line is pulled high outside the chip, and the block can only pull it low. Both lines are brought into the system clock domain through a parameterized synchronizer. The block then detects clock edges and start and stop conditions, and runs a byte-level state machine.

Every transaction opens with a 7-bit device address and a direction bit. A write sends a one-byte register pointer first, followed by data bytes. The block takes two bytes per register, high byte first, and each byte arrives most significant bit first. It commits the word with a single-cycle strobe and then advances the pointer. A read sets the pointer with a short write, then a repeated start and the read-direction address. The block then shifts out words two bytes at a time and advances the pointer after each complete word. Shifting continues until the master answers a byte with a no-acknowledge.

Top module: `twowire_reg_slave`

## Requirements
- R1: Once reset is released, the block leaves the data line released (`sda_pull_o` = 0) and the write strobe low.
- R2: When the address byte carries the device address `DEV_ADDR` in its upper seven bits, the block pulls the data line low during the acknowledge slot that follows. Bit 0 of that byte selects the direction: 0 for write, 1 for read.
- R3: When the address does not match, the block leaves the acknowledge slot high. It performs no register write and does not pull the line low until the next start or stop condition.
- R4: In a write, the first byte after the address is taken as the 8-bit register pointer and is acknowledged.
- R5: Write data bytes are acknowledged. Two bytes form one register word, the first being bits 15:8, with every byte sent MSB first. The word is committed by exactly one single-cycle strobe at the pointer address after its second byte.
- R6: After each committed word, the pointer advances by one and wraps from 0xFF to 0x00.
- R7: After a repeated start with the read-direction address, the block drives the word at the pointer, bits 15:8 first and then bits 7:0, each MSB first.
- R8: During reads, the pointer advances by one after each complete 16-bit word, so the next two bytes come from the next register.
- R9: When the master answers a read byte with a no-acknowledge, the block stops driving the line until the next start condition.
- R10: A stop or start condition ends a write. A lone trailing byte of an unfinished word is discarded without any write.
- R11: The block changes the state of the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| reg_addr_o | output | 8 | Register pointer presented to the bank |
| reg_wdata_o | output | 16 | Word to be written |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 16 | Word read from the bank at `reg_addr_o` |

## Verification
The assertions assume that the data line changes only while the clock line is low, except for start and stop conditions. They also assume that each bus level is held for several system clocks, so that the synchronizer never sees a clock edge and a data edge in the same cycle. The bench master keeps every bus phase at six system clocks. It changes the data line only after the clock line has been low for a full phase. A repeated start is formed by raising the data line before raising the clock line.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 8;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK, ST_IGN
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_PTR, PH_DATA
  } ph_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, synced, prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b11;
    else        prev <= synced;
  end

  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~prev[1];
  assign scl_fall  = ~synced[1] & prev[1];
  assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/twr_fsm.sv
module twr_fsm
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [WORD_W-1:0]  rdata_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [WORD_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               pull_o,
  output st_e                st_o
);
  st_e               st, st_n;
  ph_e               ph, ph_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, hold, hold_n, lo, lo_n;
  logic [PTR_W-1:0]  ptr, ptr_n;
  logic [WORD_W-1:0] wd, wd_n;
  logic              half, half_n, rw, rw_n, we, we_n;

  always_comb begin
    st_n = st; ph_n = ph; cnt_n = cnt; sh_n = sh; hold_n = hold; lo_n = lo;
    ptr_n = ptr; wd_n = wd; half_n = half; rw_n = rw; we_n = 1'b0;
    if (we) ptr_n = ptr + 1'b1;
    if (start_det) begin
      st_n = ST_RECV; ph_n = PH_DEV; cnt_n = '0; half_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st)
        ST_RECV: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
            cnt_n = '0;
            unique case (ph)
              PH_DEV: begin
                if (sh[7:1] == DEV_ADDR) begin rw_n = sh[0]; st_n = ST_ACK; end
                else st_n = ST_IGN;
              end
              PH_PTR: begin ptr_n = sh; half_n = 1'b0; st_n = ST_ACK; end
              default: begin
                st_n = ST_ACK;
                if (!half) begin hold_n = sh; half_n = 1'b1; end
                else begin we_n = 1'b1; wd_n = {hold, sh}; half_n = 1'b0; end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (ph == PH_DEV && rw) begin
              st_n = ST_SEND; ph_n = PH_DATA;
              sh_n = rdata_i[WORD_W-1:BYTE_W]; lo_n = rdata_i[BYTE_W-1:0];
            end else begin
              st_n = ST_RECV;
              ph_n = (ph == PH_DEV) ? PH_PTR : PH_DATA;
            end
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              st_n = ST_MACK; cnt_n = '0;
              if (half) begin half_n = 1'b0; ptr_n = ptr + 1'b1; end
              else half_n = 1'b1;
            end else begin
              sh_n  = {sh[BYTE_W-2:0], 1'b0};
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) cnt_n = {{(CNT_W-1){1'b0}}, ~sda_s};
          else if (scl_fall) begin
            if (cnt[0]) begin
              st_n = ST_SEND; cnt_n = '0;
              if (!half) begin
                sh_n = rdata_i[WORD_W-1:BYTE_W]; lo_n = rdata_i[BYTE_W-1:0];
              end else sh_n = lo;
            end else st_n = ST_IGN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_DEV; cnt <= '0; sh <= '0; hold <= '0; lo <= '0;
      ptr <= '0; wd <= '0; half <= 1'b0; rw <= 1'b0; we <= 1'b0;
    end else begin
      st <= st_n; ph <= ph_n; cnt <= cnt_n; sh <= sh_n; hold <= hold_n; lo <= lo_n;
      ptr <= ptr_n; wd <= wd_n; half <= half_n; rw <= rw_n; we <= we_n;
    end
  end

  assign pull_o  = (st == ST_ACK) | ((st == ST_SEND) & ~sh[BYTE_W-1]);
  assign ptr_o   = ptr;
  assign wdata_o = wd;
  assign we_o    = we;
  assign st_o    = st;
endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [PTR_W-1:0]   reg_addr_o,
  output logic [WORD_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  input  logic [WORD_W-1:0]  reg_rdata_i
);
  logic [1:0] rst_pipe;
  logic       rst_sn, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e        st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rdata_i(reg_rdata_i), .ptr_o(reg_addr_o), .wdata_o(reg_wdata_o),
    .we_o(reg_we_o), .pull_o(sda_pull_o), .st_o(st)
  );
endmodule

// File: rtl/twr_chk.sv
module twr_chk
  import twr_pkg::*;
(
  input logic             clk,
  input logic             rst_sn,
  input logic             sda_pull_o,
  input logic             reg_we_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input st_e              st
);
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_we_o |=> !reg_we_o);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_we_o |=> (reg_addr_o == PTR_W'($past(reg_addr_o) + 1'b1)));

  p_ign_silent_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (st == ST_IGN) |-> !sda_pull_o);

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_det |=> (st == ST_IDLE && !sda_pull_o));

  p_pull_on_low_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(sda_pull_o) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
endmodule

bind twowire_reg_slave twr_chk i_chk (
  .clk(clk), .rst_sn(rst_sn), .sda_pull_o(sda_pull_o), .reg_we_o(reg_we_o),
  .reg_addr_o(reg_addr_o), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .st(st)
);

// File: tb/test_twowire_reg_slave.sv
module test_twowire_reg_slave;
  localparam logic [6:0] DEV = 7'h48;
  localparam int Q = 6;
  localparam logic [39:0] VEC [4] = '{
    {8'h10, 16'h1234, 16'hABCD},
    {8'hFF, 16'h8001, 16'h7FFE},
    {8'h00, 16'hFFFF, 16'h0000},
    {8'h5A, 16'hA55A, 16'h3C3C}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_pull_o, reg_we_o;
  logic [7:0] reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;
  logic [15:0] bank [256];
  int checks = 0, fails = 0, wr_cnt = 0, pull_cnt = 0, hi_changes = 0;
  logic pull_d = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_o;
  assign reg_rdata_i = bank[reg_addr_o];

  twowire_reg_slave #(.DEV_ADDR(DEV)) i_twowire_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) bank[k] <= 16'(k * 16'h0101);
    end else if (reg_we_o) begin
      bank[reg_addr_o] <= reg_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (sda_pull_o === 1'b1) pull_cnt <= pull_cnt + 1;
    if (rst_n && sda_pull_o !== pull_d && scl) hi_changes <= hi_changes + 1;
    pull_d <= sda_pull_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    w(Q); sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0;
  endtask

  task automatic bstop;
    w(Q); sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic bit_out(input logic b);
    w(Q); sda_m = b; w(Q); scl = 1'b1; w(Q); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    w(Q); sda_m = 1'b1; w(Q); scl = 1'b1; w(Q - 1); b = sda_line; w(1); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack_m);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~ack_m);
  endtask

  task automatic set_ptr(input logic [7:0] p, output logic a_dev, output logic a_ptr);
    bstart;
    send_byte({DEV, 1'b0}, a_dev);
    send_byte(p, a_ptr);
  endtask

  initial begin
    int lim = 150000;
    repeat (lim) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", lim);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    logic a, b;
    logic [7:0] hi, lo, p, p1;
    int wc, pc;
    w(5); rst_n = 1'b1; w(5);
    chk("R1 pull after reset", 32'(sda_pull_o), 0);
    chk("R1 strobe after reset", 32'(reg_we_o), 0);

    for (int v = 0; v < 4; v++) begin
      p = VEC[v][39:32]; p1 = p + 8'd1; wc = wr_cnt;
      set_ptr(p, a, b);
      chk("R2 device ack", 32'(a), 1);
      chk("R4 pointer ack", 32'(b), 1);
      send_byte(VEC[v][31:24], a); send_byte(VEC[v][23:16], b);
      chk("R5 data acks", {a, b}, 2'b11);
      send_byte(VEC[v][15:8], a); send_byte(VEC[v][7:0], b);
      chk("R5 data acks word2", {a, b}, 2'b11);
      bstop;
      chk("R5 write count", wr_cnt - wc, 2);
      chk("R5 first word", 32'(bank[p]), 32'(VEC[v][31:16]));
      chk("R6 next word wraps", 32'(bank[p1]), 32'(VEC[v][15:0]));
      set_ptr(p, a, b);
      bstart;
      send_byte({DEV, 1'b1}, a);
      chk("R2 read address ack", 32'(a), 1);
      recv_byte(hi, 1'b1); recv_byte(lo, 1'b1);
      chk("R7 read word high first", {hi, lo}, 32'(VEC[v][31:16]));
      recv_byte(hi, 1'b1); recv_byte(lo, 1'b0);
      chk("R8 read next word", {hi, lo}, 32'(VEC[v][15:0]));
      bstop;
    end

    wc = wr_cnt; pc = pull_cnt;
    bstart;
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk("R3 no ack on mismatch", 32'(a), 0);
    send_byte(8'h20, a); send_byte(8'h11, a); send_byte(8'h22, a);
    bstop;
    chk("R3 no writes", wr_cnt - wc, 0);
    chk("R3 line untouched", pull_cnt - pc, 0);

    wc = wr_cnt;
    set_ptr(8'h30, a, b); send_byte(8'h99, a); bstop;
    chk("R10 lone byte dropped", wr_cnt - wc, 0);
    chk("R10 register unchanged", 32'(bank[8'h30]), 32'h3030);
    set_ptr(8'h31, a, b); send_byte(8'hBE, a); send_byte(8'hEF, a); send_byte(8'h77, a);
    bstart; send_byte({DEV, 1'b0}, a); bstop;
    chk("R10 start ends write", wr_cnt - wc, 1);
    chk("R10 word committed", 32'(bank[8'h31]), 32'hBEEF);
    chk("R10 trailing byte dropped", 32'(bank[8'h32]), 32'h3232);

    set_ptr(8'h31, a, b); bstart; send_byte({DEV, 1'b1}, a);
    recv_byte(hi, 1'b0);
    chk("R9 byte before nack", 32'(hi), 32'hBE);
    pc = pull_cnt;
    for (int i = 0; i < 8; i++) bit_in(lo[7 - i]);
    chk("R9 released after nack", pull_cnt - pc, 0);
    chk("R9 line reads high", 32'(lo), 32'hFF);
    bstop;
    chk("R11 pull changes while clock high", hi_changes, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule